// File: doc/BRIEF.md
# Synchronous SCSI Transfer Pacer

This block times the REQ side of a byte-wide parallel SCSI data phase. A single configuration byte gives two settings. The high nibble is a credit limit: the largest number of REQs that may be waiting for their ACK. The low nibble is a period code that sets how far apart successive REQ pulses are. A start strobe loads that byte together with a 16-bit byte count. The pacer then emits exactly that many REQs and counts the ACK rising edges that come back. When every byte has been acknowledged it signals completion.

A credit limit of zero selects a fully interlocked handshake instead of paced pulses. In that mode each REQ is held until ACK rises, and the next REQ waits for ACK to fall. The pacer assumes a 50 MHz logic clock. At that rate a nonzero period code `x` gives a spacing of 2·(x+2) clocks, and code 0 is the special 5-clock (100 ns) spacing. If the phase-valid input drops mid-transfer, the transfer is abandoned and a sticky phase-error flag stays up until the next start.

Top module: `sync_xfer_pacer`

## Requirements
- R1: While `rst` is high and after it is released, `req_o`, `busy_o`, `done_o` and `phase_err_o` are all 0.
- R2: In paced mode (`cfg_i[7:4]` nonzero), consecutive REQ rising edges are P clocks apart when not held back by the credit limit, where `cfg_i[3:0]`=0 gives P=5 and a code x>0 gives P=2·(x+2).
- R3: In paced mode, each REQ pulse stays high for floor(P/2) clocks, with a minimum of 1.
- R4: In paced mode, the number of REQs not yet acknowledged never exceeds `cfg_i[7:4]`. At that limit no new REQ is issued, and issuing resumes after an ACK rising edge.
- R5: With `cfg_i[7:4]`=0, REQ rises only while ACK is low and no REQ is outstanding. It stays high until ACK is seen high and falls on the next clock. The next REQ waits until ACK is low again.
- R6: A transfer issues exactly `byte_cnt_i` REQs. Each ACK rising edge counts as one byte, but only while at least one REQ is outstanding.
- R7: `done_o` is a single-cycle pulse, raised in the second clock after the final ACK rising edge. `busy_o` falls in the same cycle. A count of 0 gives a `done_o` pulse in the clock after the start and issues no REQ.
- R8: A start strobe while `busy_o` is high is ignored: the running transfer keeps its configuration and byte count.
- R9: If `phase_ok_i` is low while `busy_o` is high, then on the next clock `busy_o` and `req_o` are 0 and `phase_err_o` is 1. No `done_o` follows, and the flag stays set until the next accepted start clears it.
- R10: An accepted start with a nonzero count sets `busy_o` on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock (50 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| byte_cnt_i | input | 16 | Number of bytes to transfer |
| cfg_i | input | 8 | Credit limit in [7:4], period code in [3:0] |
| ack_i | input | 1 | ACK from the bus |
| phase_ok_i | input | 1 | High while the bus remains in the expected phase |
| req_o | output | 1 | REQ to the bus |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| phase_err_o | output | 1 | Sticky phase-loss flag |

## Verification
The assertions are checked on every clock. They cover the credit ceiling on outstanding REQs, the single-cycle shape of the completion pulse, the abort that follows a phase loss, and that an interlocked REQ only rises after ACK is low. They also check that a start arriving while busy leaves the configuration unchanged. REQ spacing, pulse width, the exact number of REQs per transfer, and the resumption after a credit stall depend on whole sequences of ACK responses, so only the bench scenarios show them. In those scenarios a modeled target answers each REQ after a chosen lag.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic {
    HS_INTERLOCK = 1'b0,
    HS_PACED     = 1'b1
  } hs_mode_e;
endpackage

// File: rtl/pacer_timing.sv
module pacer_timing #(
  parameter int NIB_W      = 4,
  parameter int TMR_W      = 7,
  parameter int UNIT_CLKS  = 2,
  parameter int CODE0_CLKS = 5
) (
  input  logic [NIB_W-1:0] code,
  output logic [TMR_W-1:0] period_len,
  output logic [TMR_W-1:0] high_len
);
  logic [TMR_W-1:0] half;

  always_comb begin
    if (code == '0) period_len = TMR_W'(CODE0_CLKS);
    else            period_len = TMR_W'(UNIT_CLKS * (int'(code) + 2));
    half     = period_len >> 1;
    high_len = (half == '0) ? TMR_W'(1) : half;
  end
endmodule

// File: rtl/pacer_credit.sv
module pacer_credit #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec,
  output logic [NIB_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pacer_req_gen.sv
module pacer_req_gen #(
  parameter int TMR_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             interlock,
  input  logic             can_issue,
  input  logic             ack_i,
  input  logic [TMR_W-1:0] period_len,
  input  logic [TMR_W-1:0] high_len,
  output logic             req_o,
  output logic             issue
);
  logic [TMR_W-1:0] tmr, tmr_nx;
  logic             req_nx;

  always_comb begin
    issue  = 1'b0;
    tmr_nx = '0;
    req_nx = 1'b0;
    if (en) begin
      if (interlock) begin
        issue  = !req_o && !ack_i && can_issue;
        req_nx = issue || (req_o && !ack_i);
      end else begin
        if (tmr == '0) begin
          issue  = can_issue;
          tmr_nx = issue ? TMR_W'(1) : '0;
        end else begin
          tmr_nx = (tmr == period_len - 1'b1) ? '0 : tmr + 1'b1;
        end
        req_nx = (tmr_nx != '0) && (tmr_nx <= high_len);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr   <= '0;
      req_o <= 1'b0;
    end else begin
      tmr   <= tmr_nx;
      req_o <= req_nx;
    end
  end
endmodule

// File: rtl/sync_xfer_pacer.sv
module sync_xfer_pacer
  import pacer_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int NIB_W      = 4,
  parameter int TMR_W      = 7,
  parameter int UNIT_CLKS  = 2,
  parameter int CODE0_CLKS = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   byte_cnt_i,
  input  logic [2*NIB_W-1:0] cfg_i,
  input  logic               ack_i,
  input  logic               phase_ok_i,
  output logic               req_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               phase_err_o
);
  localparam int CFG_W = 2 * NIB_W;

  logic [CFG_W-1:0] cfg_q;
  logic [NIB_W-1:0] offset_q, code_q, outst;
  logic [CNT_W-1:0] remaining, to_issue;
  logic [TMR_W-1:0] period_len, high_len;
  logic             ack_q, ack_rise, ack_take, start_go;
  logic             credit_ok, can_issue, issue, en, interlock;
  hs_mode_e         mode;

  assign offset_q  = cfg_q[CFG_W-1:NIB_W];
  assign code_q    = cfg_q[NIB_W-1:0];
  assign mode      = (offset_q == '0) ? HS_INTERLOCK : HS_PACED;
  assign interlock = (mode == HS_INTERLOCK);
  assign start_go  = start_i && !busy_o;
  assign ack_rise  = ack_i && !ack_q;
  assign ack_take  = busy_o && ack_rise && (outst != '0);
  assign en        = busy_o && phase_ok_i;
  assign credit_ok = interlock ? (outst == '0) : (outst < offset_q);
  assign can_issue = (to_issue != '0) && credit_ok;

  pacer_timing #(
    .NIB_W(NIB_W), .TMR_W(TMR_W), .UNIT_CLKS(UNIT_CLKS), .CODE0_CLKS(CODE0_CLKS)
  ) u_timing (
    .code(code_q), .period_len(period_len), .high_len(high_len)
  );

  pacer_credit #(.NIB_W(NIB_W)) u_credit (
    .clk(clk), .rst(rst), .clr(start_go), .inc(issue), .dec(ack_take), .count(outst)
  );

  pacer_req_gen #(.TMR_W(TMR_W)) u_req (
    .clk(clk), .rst(rst), .en(en), .interlock(interlock), .can_issue(can_issue),
    .ack_i(ack_i), .period_len(period_len), .high_len(high_len),
    .req_o(req_o), .issue(issue)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q       <= 1'b0;
      cfg_q       <= '0;
      remaining   <= '0;
      to_issue    <= '0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      phase_err_o <= 1'b0;
    end else begin
      ack_q  <= ack_i;
      done_o <= 1'b0;
      if (start_go) begin
        cfg_q       <= cfg_i;
        remaining   <= byte_cnt_i;
        to_issue    <= byte_cnt_i;
        phase_err_o <= 1'b0;
        if (byte_cnt_i == '0) done_o <= 1'b1;
        else                  busy_o <= 1'b1;
      end else if (busy_o) begin
        if (!phase_ok_i) begin
          busy_o      <= 1'b0;
          phase_err_o <= 1'b1;
        end else begin
          if (issue) to_issue <= to_issue - 1'b1;
          if (ack_take && remaining != '0) remaining <= remaining - 1'b1;
          if (remaining == '0 && outst == '0) begin
            done_o <= 1'b1;
            busy_o <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pacer_checker.sv
module pacer_checker #(
  parameter int CNT_W = 16,
  parameter int NIB_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic [CNT_W-1:0]   byte_cnt_i,
  input logic               ack_i,
  input logic               phase_ok_i,
  input logic               req_o,
  input logic               busy_o,
  input logic               done_o,
  input logic               phase_err_o,
  input logic [NIB_W-1:0]   outst,
  input logic [NIB_W-1:0]   offset_q,
  input logic [2*NIB_W-1:0] cfg_q,
  input logic               interlock
);
  AST_CREDIT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !interlock) |-> (outst <= offset_q)); // R4

  AST_INTERLOCK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && interlock) |-> (outst <= 1)); // R5

  AST_INTERLOCK_WAIT: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_o) && interlock) |-> $past(!ack_i)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R7

  AST_START_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(cfg_q)); // R8

  AST_PHASE_ABORT: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !phase_ok_i) |=> (!busy_o && !req_o && phase_err_o)); // R9

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && byte_cnt_i != '0) |=> busy_o); // R10
endmodule

bind sync_xfer_pacer pacer_checker #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
  .ack_i(ack_i), .phase_ok_i(phase_ok_i), .req_o(req_o), .busy_o(busy_o),
  .done_o(done_o), .phase_err_o(phase_err_o), .outst(outst),
  .offset_q(offset_q), .cfg_q(cfg_q), .interlock(interlock)
);

// File: tb/sync_xfer_pacer_bench.sv
`timescale 1ns/1ps
module sync_xfer_pacer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] byte_cnt_i = '0;
  logic [7:0]  cfg_i = '0;
  logic        ack_i = 1'b0;
  logic        phase_ok_i = 1'b1;
  logic        req_o, busy_o, done_o, phase_err_o;

  sync_xfer_pacer u_sync_xfer_pacer (
    .clk(clk), .rst(rst), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
    .cfg_i(cfg_i), .ack_i(ack_i), .phase_ok_i(phase_ok_i), .req_o(req_o),
    .busy_o(busy_o), .done_o(done_o), .phase_err_o(phase_err_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // monitor and modeled target
  int rises, dones, hi_first, first_rise, second_rise, cyc, out_b, out_max;
  bit req_prev = 0, ack_prev = 0;
  bit resp_en = 0, resp_async = 0;
  int resp_lag = 1, dly = 0;
  logic [31:0] pipe = '0;

  initial forever begin
    bit rise;
    @(negedge clk);
    cyc++;
    rise = req_o && !req_prev;
    if (rise) begin
      rises++;
      out_b++;
      if (out_b > out_max) out_max = out_b;
      if (rises == 1) first_rise = cyc;
      if (rises == 2) second_rise = cyc;
    end
    if (req_o && rises == 1) hi_first++;
    if (done_o) dones++;
    req_prev = req_o;
    if (resp_en) begin
      if (resp_async) begin
        if (req_o && !ack_i) begin
          if (dly >= resp_lag) begin ack_i = 1'b1; dly = 0; end
          else dly++;
        end else if (!req_o && ack_i) ack_i = 1'b0;
      end else begin
        pipe  = {pipe[30:0], rise};
        ack_i = pipe[resp_lag];
      end
      if (ack_i && !ack_prev) out_b--;
    end else begin
      pipe = '0;
      dly  = 0;
    end
    ack_prev = ack_i;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    rises = 0; dones = 0; hi_first = 0; first_rise = 0;
    second_rise = 0; cyc = 0; out_b = 0; out_max = 0;
  endtask

  task automatic pulse_start(input logic [7:0] p, input logic [15:0] c);
    cfg_i = p; byte_cnt_i = c; start_i = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (dones > 0 && !busy_o) break;
      tick();
    end
  endtask

  task automatic drain();
    resp_en = 0; ack_i = 1'b0;
    repeat (40) tick();
  endtask

  // {cfg, count, target lag, expected period, expected REQ width}; 0 = not checked
  localparam logic [39:0] VEC [7] = '{
    {8'h21, 8'd4, 8'd3,  8'd6,  8'd3},
    {8'h40, 8'd3, 8'd2,  8'd5,  8'd2},
    {8'hF3, 8'd5, 8'd20, 8'd10, 8'd5},
    {8'h1F, 8'd2, 8'd1,  8'd34, 8'd17},
    {8'h35, 8'd6, 8'd9,  8'd14, 8'd7},
    {8'h02, 8'd3, 8'd2,  8'd0,  8'd0},
    {8'h00, 8'd2, 8'd0,  8'd0,  8'd0}
  };

  initial begin
    repeat (4) tick();
    chk(!req_o && !busy_o && !done_o && !phase_err_o, "R1 outputs in reset",
        {req_o, busy_o, done_o, phase_err_o}, 0);
    rst = 1'b0;
    tick();
    chk(!req_o && !busy_o && !done_o && !phase_err_o, "R1 outputs after reset",
        {req_o, busy_o, done_o, phase_err_o}, 0);

    foreach (VEC[k]) begin
      logic [7:0] p;
      int cnt, per, hi;
      p = VEC[k][39:32]; cnt = VEC[k][31:24];
      per = VEC[k][15:8]; hi = VEC[k][7:0];
      resp_lag = VEC[k][23:16];
      resp_async = (p[7:4] == 0);
      resp_en = 1;
      clear_mon();
      pulse_start(p, 16'(cnt));
      chk(busy_o, "R10 busy after start", busy_o, 1);
      wait_idle();
      repeat (3) tick();
      chk(rises == cnt, "R6 REQ count", rises, cnt);
      chk(dones == 1, "R7 done pulses", dones, 1);
      chk(!busy_o, "R7 idle after done", busy_o, 0);
      if (per != 0) begin
        chk(second_rise - first_rise == per, "R2 REQ spacing", second_rise - first_rise, per);
        chk(hi_first == hi, "R3 REQ width", hi_first, hi);
        chk(out_max <= int'(p[7:4]), "R4 outstanding ceiling", out_max, p[7:4]);
      end else begin
        chk(out_max <= 1, "R5 one outstanding in interlock", out_max, 1);
      end
      drain();
    end

    // R4: credit stall with a limit of 1, target silent
    clear_mon();
    pulse_start(8'h12, 16'd3);
    repeat (60) tick();
    chk(rises == 1, "R4 stalled at limit", rises, 1);
    chk(busy_o, "R4 busy while stalled", busy_o, 1);
    for (int a = 0; a < 3; a++) begin
      ack_i = 1'b1; tick(); ack_i = 1'b0;
      repeat (40) tick();
      if (a < 2) chk(rises == a + 2, "R4 resume after ACK", rises, a + 2);
    end
    chk(rises == 3 && dones == 1 && !busy_o, "R6 stalled transfer completes", rises, 3);

    // R5: interlocked handshake driven by hand
    clear_mon();
    pulse_start(8'h02, 16'd2);
    repeat (10) tick();
    chk(req_o, "R5 REQ raised", req_o, 1);
    repeat (20) tick();
    chk(req_o, "R5 REQ held without ACK", req_o, 1);
    ack_i = 1'b1; tick(); tick();
    chk(!req_o, "R5 REQ falls after ACK", req_o, 0);
    repeat (10) tick();
    chk(!req_o && rises == 1, "R5 no REQ while ACK high", rises, 1);
    ack_i = 1'b0; repeat (3) tick();
    chk(req_o && rises == 2, "R5 next REQ after ACK low", rises, 2);
    ack_i = 1'b1; tick(); tick(); ack_i = 1'b0;
    repeat (5) tick();
    chk(dones == 1 && !busy_o, "R7 interlocked done", dones, 1);
    drain();

    // R7: zero byte count
    clear_mon();
    pulse_start(8'h21, 16'd0);
    chk(done_o && !busy_o, "R7 zero-count done", done_o, 1);
    tick();
    chk(!done_o, "R7 done is one cycle", done_o, 0);
    repeat (10) tick();
    chk(rises == 0, "R7 zero-count issues no REQ", rises, 0);

    // R8: start while busy is ignored
    clear_mon();
    resp_async = 0; resp_lag = 3; resp_en = 1;
    pulse_start(8'h21, 16'd4);
    repeat (10) tick();
    pulse_start(8'h40, 16'd9);
    wait_idle();
    repeat (3) tick();
    chk(rises == 4, "R8 second start ignored", rises, 4);
    chk(dones == 1, "R8 single completion", dones, 1);
    drain();

    // R9: phase loss mid-transfer
    clear_mon();
    resp_async = 0; resp_lag = 3; resp_en = 1;
    pulse_start(8'h21, 16'd10);
    repeat (20) tick();
    phase_ok_i = 1'b0;
    tick();
    chk(!busy_o && !req_o && phase_err_o, "R9 abort on phase loss",
        {busy_o, req_o, phase_err_o}, 1);
    begin
      int r0;
      r0 = rises;
      repeat (20) tick();
      chk(rises == r0 && dones == 0, "R9 no REQ or done after abort", rises, r0);
    end
    chk(phase_err_o, "R9 flag sticky", phase_err_o, 1);
    phase_ok_i = 1'b1;
    drain();
    clear_mon();
    resp_async = 0; resp_lag = 2; resp_en = 1;
    pulse_start(8'h40, 16'd2);
    chk(!phase_err_o, "R9 flag cleared by start", phase_err_o, 0);
    wait_idle();
    chk(dones == 1 && rises == 2, "R9 transfer after recovery", rises, 2);
    drain();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule